// File: doc/BRIEF.md
# Segmented 16-bit Instruction Sequencer

This block is a small multi-cycle processor core that runs a narrow subset of a 16-bit segmented x86-style instruction set. Each byte of code is fetched over an 8-bit read port. The 20-bit physical address is formed from the code segment shifted left by four, plus the instruction pointer. Port input and output use a separate 16-bit channel that has its own strobe and a write qualifier. Both channels use a valid/ready handshake, so a memory or peripheral model can stretch any access by holding ready low.

The core holds the eight general and pointer registers, the code segment, the instruction pointer and a flag set. The flag set is exposed as a 16-bit word in which the reserved positions always read as one. The core executes these instructions:
- no-operation
- register loads from an immediate, byte or word
- port reads and writes, with the port number taken from an immediate or from DX
- a far jump
- set and clear of the carry, interrupt and direction flags

Any other opcode stops the core for good, until the next reset. An executed-instruction counter lets a system observe progress.

Top module: `segcore_top`

## Requirements
- R1: After reset the core shows CS=0xFFFF, IP=0, all general registers 0, `flags_word`=0xF002, `halted`=0 and `instr_count`=0, and its first request is a code fetch at 0xFFFF0.
- R2: Every code fetch uses address (CS*16 + IP) modulo 2^20. IP advances by one for each accepted byte, and `mem_addr` and `mem_valid` hold steady while `mem_ready` is low.
- R3: Word immediates arrive low byte first, from two consecutive IP values.
- R4: Opcodes 0xB0..0xB7 load a byte into AL, CL, DL, BL, AH, CH, DH, BH in that order. Opcodes 0xB8..0xBF load a word into AX, CX, DX, BX, SP, BP, SI, DI in that order. `gpr_file` bits [16n+15:16n] hold word register n in that same order.
- R5: Opcode 0xEA fetches a new IP word and then a new CS word. The next fetch comes from the new pair.
- R6: 0xF8/0xF9 clear/set carry (bit 0), 0xFA/0xFB clear/set interrupt (bit 9), and 0xFC/0xFD clear/set direction (bit 10). 0x90 changes nothing. Bits 14, 13, 12 and 1 of `flags_word` always read 1, and bit 15 is the mode flag.
- R7: 0xE4/0xE5 read the port named by an 8-bit immediate, and 0xEC/0xED read the port named by DX. The byte forms copy only `io_rdata[7:0]` into AL and leave AH unchanged. The word forms load AX.
- R8: 0xE6/0xE7 and 0xEE/0xEF write AL or AX to the immediate port or to the DX port, with `io_write`=1. The byte forms drive `io_wdata[15:8]` as zero.
- R9: Any opcode outside the supported set raises `halted`. After that the core makes no memory or port request until reset, and the failing opcode is not counted.
- R10: `instr_count` rises by exactly one for each supported opcode executed.
- R11: After each opcode fetch is accepted, exactly one idle cycle passes before the next request. With a zero-wait memory, a run of 0x90 opcodes is fetched every two cycles.
- R12: A memory request and a port request are never raised together, and a port request holds its address, data and direction steady until `io_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_valid | output | 1 | Code fetch request |
| mem_addr | output | 20 | Physical fetch address |
| mem_rdata | input | 8 | Fetched byte, valid with mem_ready |
| mem_ready | input | 1 | Fetch completes this cycle |
| io_valid | output | 1 | Port access request |
| io_write | output | 1 | 1 for a port write, 0 for a port read |
| io_addr | output | 16 | Port number |
| io_wdata | output | 16 | Port write data |
| io_rdata | input | 16 | Port read data, valid with io_ready |
| io_ready | input | 1 | Port access completes this cycle |
| halted | output | 1 | Core stopped on an unsupported opcode |
| instr_count | output | 32 | Executed-instruction count |
| flags_word | output | 16 | Packed flag word |
| seg_cs | output | 16 | Code segment |
| ip | output | 16 | Instruction pointer |
| gpr_file | output | 128 | Word registers AX, CX, DX, BX, SP, BP, SI, DI, register n at bits [16n+15:16n] |

## Verification
A fetch is accepted at the first rising edge where `mem_ready` is high. Register and IP results change at that same edge. An opcode's own effect (flags, count, halt) lands one edge later, at the end of the idle cycle, and a port read result lands at the edge where `io_ready` is high. For that reason the bench drives ready and data on falling edges, runs each program until `halted` rises, and reads the architectural outputs on the next falling edge. By then every earlier register update has settled. Cycle spacing is checked by stamping each accepted fetch with a cycle count on the rising edge and comparing differences against the two-cycle pitch of R11. The wait-state scenario checks that the fetch order and the results do not depend on how long ready stays low.

// File: rtl/segcore_pkg.sv
package segcore_pkg;

    typedef enum logic [2:0] {
        ST_FETCH, ST_WAIT, ST_IMM_LO, ST_IMM_HI,
        ST_SEG_LO, ST_SEG_HI, ST_PORT, ST_HALT
    } seq_state_e;

    typedef enum logic [3:0] {
        K_NOP, K_MOVB, K_MOVW, K_IN_IMM, K_OUT_IMM,
        K_IN_DX, K_OUT_DX, K_JMPF, K_FLAG, K_BAD
    } op_kind_e;

    typedef enum logic [1:0] {
        FS_CARRY = 2'd0,
        FS_INTR  = 2'd1,
        FS_DIR   = 2'd2,
        FS_NONE  = 2'd3
    } flag_sel_e;

    typedef struct packed {
        op_kind_e  kind;
        logic      wide;
        logic [2:0] idx;
        flag_sel_e fsel;
        logic      fval;
    } op_info_t;

    typedef struct packed {
        logic mode;
        logic ovf;
        logic dir;
        logic intr;
        logic brk;
        logic sign;
        logic zero;
        logic half;
        logic par;
        logic carry;
    } flag_bits_t;

    function automatic flag_bits_t flags_from_word(input logic [15:0] w);
        flag_bits_t f;
        f.mode  = w[15];
        f.ovf   = w[11];
        f.dir   = w[10];
        f.intr  = w[9];
        f.brk   = w[8];
        f.sign  = w[7];
        f.zero  = w[6];
        f.half  = w[4];
        f.par   = w[2];
        f.carry = w[0];
        return f;
    endfunction

endpackage

// File: rtl/segcore_decode.sv
module segcore_decode
    import segcore_pkg::*;
(
    input  logic [7:0] opcode,
    output op_info_t   info
);
    always_comb begin
        info.kind = K_BAD;
        info.wide = opcode[0];
        info.idx  = opcode[2:0];
        info.fsel = FS_NONE;
        info.fval = opcode[0];
        if (opcode[7:4] == 4'hB) begin
            info.kind = opcode[3] ? K_MOVW : K_MOVB;
            info.wide = opcode[3];
        end else begin
            unique case (opcode)
                8'h90:        info.kind = K_NOP;
                8'hE4, 8'hE5: info.kind = K_IN_IMM;
                8'hE6, 8'hE7: info.kind = K_OUT_IMM;
                8'hEC, 8'hED: info.kind = K_IN_DX;
                8'hEE, 8'hEF: info.kind = K_OUT_DX;
                8'hEA:        info.kind = K_JMPF;
                8'hF8, 8'hF9, 8'hFA, 8'hFB, 8'hFC, 8'hFD: begin
                    info.kind = K_FLAG;
                    info.fsel = flag_sel_e'(opcode[2:1]);
                end
                default:      info.kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/segcore_flagpack.sv
module segcore_flagpack
    import segcore_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  flag_bits_t        fl,
    output logic [WORD_W-1:0] word
);
    // reserved positions 14..12 and 1 are fixed high, 5 and 3 fixed low
    always_comb begin
        word     = '0;
        word[15] = fl.mode;
        word[14] = 1'b1;
        word[13] = 1'b1;
        word[12] = 1'b1;
        word[11] = fl.ovf;
        word[10] = fl.dir;
        word[9]  = fl.intr;
        word[8]  = fl.brk;
        word[7]  = fl.sign;
        word[6]  = fl.zero;
        word[4]  = fl.half;
        word[2]  = fl.par;
        word[1]  = 1'b1;
        word[0]  = fl.carry;
    end
endmodule

// File: rtl/segcore_top.sv
module segcore_top
    import segcore_pkg::*;
#(
    parameter int          PA_W        = 20,
    parameter int          SEG_SHIFT   = 4,
    parameter int          CNT_W       = 32,
    parameter int          NREG        = 8,
    parameter logic [15:0] RESET_CS    = 16'hFFFF,
    parameter logic [15:0] RESET_FLAGS = 16'h8000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 mem_valid,
    output logic [PA_W-1:0]      mem_addr,
    input  logic [7:0]           mem_rdata,
    input  logic                 mem_ready,
    output logic                 io_valid,
    output logic                 io_write,
    output logic [15:0]          io_addr,
    output logic [15:0]          io_wdata,
    input  logic [15:0]          io_rdata,
    input  logic                 io_ready,
    output logic                 halted,
    output logic [CNT_W-1:0]     instr_count,
    output logic [15:0]          flags_word,
    output logic [15:0]          seg_cs,
    output logic [15:0]          ip,
    output logic [NREG*16-1:0]   gpr_file
);
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int SEGW   = WORD_W + SEG_SHIFT;
    localparam int ACC    = 0;   // AX slot
    localparam int DXR    = 2;   // DX slot

    typedef struct packed {
        seq_state_e                    st;
        logic [BYTE_W-1:0]             op;
        logic [WORD_W-1:0]             tmp;
        logic [WORD_W-1:0]             port;
        logic [WORD_W-1:0]             ipr;
        logic [WORD_W-1:0]             csr;
        logic [NREG-1:0][WORD_W-1:0]   gpr;
        flag_bits_t                    fl;
        logic                          halted;
        logic [CNT_W-1:0]              count;
    } core_t;

    core_t    s_q, s_d, rst_val;
    op_info_t info;
    logic [SEGW-1:0] seg_base;

    segcore_decode u_decode (
        .opcode (s_q.op),
        .info   (info)
    );

    segcore_flagpack #(.WORD_W(WORD_W)) u_flagpack (
        .fl   (s_q.fl),
        .word (flags_word)
    );

    always_comb begin
        rst_val        = '0;
        rst_val.st     = ST_FETCH;
        rst_val.csr    = RESET_CS;
        rst_val.fl     = flags_from_word(RESET_FLAGS);
    end

    assign seg_base = {s_q.csr, {SEG_SHIFT{1'b0}}};

    always_comb begin
        s_d       = s_q;
        mem_valid = 1'b0;
        io_valid  = 1'b0;
        mem_addr  = PA_W'(seg_base) + PA_W'(s_q.ipr);
        io_addr   = s_q.port;
        io_write  = (info.kind == K_OUT_IMM) || (info.kind == K_OUT_DX);
        io_wdata  = info.wide ? s_q.gpr[ACC] : {8'h00, s_q.gpr[ACC][BYTE_W-1:0]};

        unique case (s_q.st)
            ST_FETCH: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    s_d.op  = mem_rdata;
                    s_d.ipr = s_q.ipr + 16'd1;
                    s_d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (info.kind == K_BAD) begin
                    s_d.halted = 1'b1;
                    s_d.st     = ST_HALT;
                end else begin
                    s_d.count = s_q.count + CNT_W'(1);
                    unique case (info.kind)
                        K_NOP: s_d.st = ST_FETCH;
                        K_FLAG: begin
                            unique case (info.fsel)
                                FS_CARRY: s_d.fl.carry = info.fval;
                                FS_INTR:  s_d.fl.intr  = info.fval;
                                FS_DIR:   s_d.fl.dir   = info.fval;
                                default:  ;
                            endcase
                            s_d.st = ST_FETCH;
                        end
                        K_IN_DX, K_OUT_DX: begin
                            s_d.port = s_q.gpr[DXR];
                            s_d.st   = ST_PORT;
                        end
                        default: s_d.st = ST_IMM_LO;
                    endcase
                end
            end
            ST_IMM_LO: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    s_d.ipr      = s_q.ipr + 16'd1;
                    s_d.tmp[7:0] = mem_rdata;
                    unique case (info.kind)
                        K_MOVB: begin
                            if (info.idx[2]) s_d.gpr[info.idx[1:0]][15:8] = mem_rdata;
                            else             s_d.gpr[info.idx[1:0]][7:0]  = mem_rdata;
                            s_d.st = ST_FETCH;
                        end
                        K_IN_IMM, K_OUT_IMM: begin
                            s_d.port = {8'h00, mem_rdata};
                            s_d.st   = ST_PORT;
                        end
                        default: s_d.st = ST_IMM_HI;
                    endcase
                end
            end
            ST_IMM_HI: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    s_d.ipr       = s_q.ipr + 16'd1;
                    s_d.tmp[15:8] = mem_rdata;
                    if (info.kind == K_MOVW) begin
                        s_d.gpr[info.idx] = {mem_rdata, s_q.tmp[7:0]};
                        s_d.st = ST_FETCH;
                    end else begin
                        s_d.st = ST_SEG_LO;
                    end
                end
            end
            ST_SEG_LO: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    s_d.ipr       = s_q.ipr + 16'd1;
                    s_d.port[7:0] = mem_rdata;
                    s_d.st        = ST_SEG_HI;
                end
            end
            ST_SEG_HI: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    s_d.ipr = s_q.tmp;
                    s_d.csr = {mem_rdata, s_q.port[7:0]};
                    s_d.st  = ST_FETCH;
                end
            end
            ST_PORT: begin
                io_valid = 1'b1;
                if (io_ready) begin
                    if (!io_write) begin
                        if (info.wide) s_d.gpr[ACC] = io_rdata;
                        else           s_d.gpr[ACC][7:0] = io_rdata[7:0];
                    end
                    s_d.st = ST_FETCH;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= rst_val;
        else        s_q <= s_d;
    end

    assign halted      = s_q.halted;
    assign instr_count = s_q.count;
    assign seg_cs      = s_q.csr;
    assign ip          = s_q.ipr;
    assign gpr_file    = s_q.gpr;

    // ---------------- assertions ----------------
    assert_ip_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && s_q.st != ST_SEG_HI) |=> (ip == $past(ip) + 16'd1));

    assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_valid && !io_valid));

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (instr_count == $past(instr_count) ||
                  instr_count == $past(instr_count) + CNT_W'(1)));

    assert_gap_after_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && s_q.st == ST_FETCH) |=> (!mem_valid && !io_valid));

    assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && io_valid));

    assert_port_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_ready) |=> (io_valid && $stable(io_addr) &&
                                     $stable(io_wdata) && $stable(io_write)));
endmodule

// File: tb/test_segcore_top.sv
`timescale 1ns/1ps
module test_segcore_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_valid, io_valid, io_write, halted;
    logic [19:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_ready = 1'b0;
    logic [15:0] io_addr, io_wdata, flags_word, seg_cs, ip;
    logic [15:0] io_rdata = 16'h0000;
    logic        io_ready = 1'b0;
    logic [31:0] instr_count;
    logic [127:0] gpr_file;

    int nchecks = 0;
    int nfails  = 0;
    int cyc = 0;
    int mem_waits = 0, io_waits = 0, mwc = 0, iwc = 0;

    logic [7:0]  mem [int];
    logic [7:0]  prog [$];
    int          fcyc [$];
    logic [19:0] faddr [$];
    logic [15:0] wport [$];
    logic [15:0] wdat [$];
    logic [15:0] rport [$];

    always #2 clk = ~clk;   // 250 MHz

    segcore_top i_segcore_top (
        .clk(clk), .rst_n(rst_n),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ready(io_ready),
        .halted(halted), .instr_count(instr_count), .flags_word(flags_word),
        .seg_cs(seg_cs), .ip(ip), .gpr_file(gpr_file)
    );

    function automatic logic [7:0] rd(input logic [19:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'hFF;
    endfunction

    function automatic logic [15:0] port_val(input logic [15:0] p);
        return p ^ 16'h5AC3;
    endfunction

    function automatic logic [15:0] g(input int n);
        return gpr_file[16*n +: 16];
    endfunction

    // responders: drive on falling edges
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0; io_ready = 1'b0; mwc = 0; iwc = 0;
        end else begin
            if (mem_valid) begin
                if (mwc >= mem_waits) begin mem_ready = 1'b1; mem_rdata = rd(mem_addr); end
                else begin mem_ready = 1'b0; mwc++; end
            end else mem_ready = 1'b0;
            if (io_valid) begin
                if (iwc >= io_waits) begin io_ready = 1'b1; io_rdata = port_val(io_addr); end
                else begin io_ready = 1'b0; iwc++; end
            end else io_ready = 1'b0;
        end
    end

    // monitor: log accepted transfers on rising edges
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_valid && mem_ready) begin
                mwc = 0; fcyc.push_back(cyc); faddr.push_back(mem_addr);
            end
            if (io_valid && io_ready) begin
                iwc = 0;
                if (io_write) begin wport.push_back(io_addr); wdat.push_back(io_wdata); end
                else rport.push_back(io_addr);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start(input int mw, input int iw);
        rst_n = 1'b0;
        mem.delete(); fcyc.delete(); faddr.delete();
        wport.delete(); wdat.delete(); rport.delete();
        mem_waits = mw; io_waits = iw;
        for (int i = 0; i < prog.size(); i++) mem[(32'hFFFF0 + i) & 32'hFFFFF] = prog[i];
        repeat (2) @(negedge clk);
    endtask

    task automatic run();
        int t = 0;
        rst_n = 1'b1;
        while (!halted && t < 3000) begin @(negedge clk); t++; end
        check("watchdog_run", {31'd0, halted}, 32'd1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        prog = '{};
        start(0, 0);
        rst_n = 1'b1;
        check("R1 cs", {16'd0, seg_cs}, 32'hFFFF);
        check("R1 ip", {16'd0, ip}, 32'h0);
        check("R1 gpr", {31'd0, gpr_file == '0}, 32'd1);
        check("R1 flags", {16'd0, flags_word}, 32'hF002);
        check("R1 halted", {31'd0, halted}, 32'd0);
        check("R1 count", instr_count, 32'd0);
        check("R1 first fetch valid", {31'd0, mem_valid}, 32'd1);
        check("R1 first fetch addr", {12'd0, mem_addr}, 32'hFFFF0);
        run();
    endtask

    task automatic t_movb();
        prog = '{8'hB0,8'h11, 8'hB1,8'h22, 8'hB2,8'h33, 8'hB3,8'h44,
                 8'hB4,8'h55, 8'hB5,8'h66, 8'hB6,8'h77, 8'hB7,8'h88, 8'hFF};
        start(0, 0); run();
        check("R4 AX", {16'd0, g(0)}, 32'h5511);
        check("R4 CX", {16'd0, g(1)}, 32'h6622);
        check("R4 DX", {16'd0, g(2)}, 32'h7733);
        check("R4 BX", {16'd0, g(3)}, 32'h8844);
        check("R10 count movb", instr_count, 32'd8);
        check("R2 ip after", {16'd0, ip}, 32'd17);
        check("R2 wrap addr", {12'd0, faddr[faddr.size()-1]}, 32'h00000);
    endtask

    task automatic t_movw();
        prog = '{};
        for (int n = 0; n < 8; n++) begin
            prog.push_back(8'hB8 + 8'(n)); prog.push_back(8'h01 + 8'(n)); prog.push_back(8'hA0 + 8'(n));
        end
        prog.push_back(8'hFF);
        start(0, 0); run();
        for (int n = 0; n < 8; n++)
            check("R3 R4 word reg", {16'd0, g(n)}, {16'd0, 8'hA0 + 8'(n), 8'h01 + 8'(n)});
        check("R10 count movw", instr_count, 32'd8);
        check("R2 ip movw", {16'd0, ip}, 32'd25);
    endtask

    task automatic t_jmpf();
        prog = '{8'hEA, 8'h34, 8'h12, 8'h00, 8'h20};
        start(0, 0);
        mem[32'h21234] = 8'hB0; mem[32'h21235] = 8'h5A;
        run();
        check("R5 cs", {16'd0, seg_cs}, 32'h2000);
        check("R5 ip", {16'd0, ip}, 32'h1237);
        check("R5 AX", {16'd0, g(0)}, 32'h005A);
        check("R5 target addr", {12'd0, faddr[5]}, 32'h21234);
        check("R10 count jmp", instr_count, 32'd2);
        prog = '{8'hEA, 8'h20, 8'h00, 8'hFF, 8'hFF};
        start(0, 0);
        mem[32'h00010] = 8'hB8; mem[32'h00011] = 8'hCD; mem[32'h00012] = 8'hAB;
        run();
        check("R2 truncated target", {12'd0, faddr[5]}, 32'h00010);
        check("R5 AX wrap", {16'd0, g(0)}, 32'hABCD);
        check("R5 ip wrap", {16'd0, ip}, 32'h0024);
    endtask

    task automatic t_flags();
        prog = '{8'hF9, 8'hFF};
        start(0, 0); run();
        check("R6 carry set", {16'd0, flags_word}, 32'hF003);
        prog = '{8'hF9, 8'hFB, 8'hFD, 8'h90, 8'hFF};
        start(0, 0); run();
        check("R6 all set", {16'd0, flags_word}, 32'hF603);
        check("R10 count flags", instr_count, 32'd4);
        check("R6 nop regs untouched", {31'd0, gpr_file == '0}, 32'd1);
        prog = '{8'hF9, 8'hFB, 8'hFD, 8'hF8, 8'hFA, 8'hFC, 8'hFF};
        start(0, 0); run();
        check("R6 all cleared", {16'd0, flags_word}, 32'hF002);
    endtask

    task automatic t_in();
        prog = '{8'hBA, 8'h34, 8'h12, 8'hB4, 8'h77, 8'hE4, 8'h40, 8'hFF};
        start(0, 0); run();
        check("R7 byte in keeps AH", {16'd0, g(0)}, 32'h7783);
        check("R7 port imm", {16'd0, rport[0]}, 32'h0040);
        prog = '{8'hBA, 8'h34, 8'h12, 8'hE5, 8'h41, 8'hEC, 8'hFF};
        start(0, 0); run();
        check("R7 word then dx byte", {16'd0, g(0)}, 32'h5AF7);
        check("R7 dx port", {16'd0, rport[1]}, 32'h1234);
        prog = '{8'hBA, 8'h34, 8'h12, 8'hED, 8'hFF};
        start(0, 0); run();
        check("R7 dx word", {16'd0, g(0)}, 32'h48F7);
        check("R7 no writes", wport.size(), 32'd0);
    endtask

    task automatic t_out();
        prog = '{8'hB8, 8'hEF, 8'hBE, 8'hBA, 8'h00, 8'h80,
                 8'hE6, 8'h12, 8'hE7, 8'h13, 8'hEE, 8'hEF, 8'hFF};
        start(0, 0); run();
        check("R8 write count", wport.size(), 32'd4);
        check("R8 port0", {16'd0, wport[0]}, 32'h0012);
        check("R8 byte data zero-high", {16'd0, wdat[0]}, 32'h00EF);
        check("R8 word data", {16'd0, wdat[1]}, 32'hBEEF);
        check("R8 dx port", {16'd0, wport[2]}, 32'h8000);
        check("R8 dx byte", {16'd0, wdat[2]}, 32'h00EF);
        check("R8 dx word", {16'd0, wdat[3]}, 32'hBEEF);
        check("R10 count out", instr_count, 32'd6);
    endtask

    task automatic t_halt();
        int seen = 0;
        int nf;
        prog = '{8'h90, 8'h0F, 8'hB0, 8'h99};
        start(0, 0); run();
        nf = faddr.size();
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_valid || io_valid) seen++;
        end
        check("R9 halted", {31'd0, halted}, 32'd1);
        check("R9 no requests", seen, 32'd0);
        check("R9 no fetches", faddr.size(), nf);
        check("R9 failing not counted", instr_count, 32'd1);
        check("R9 ip past bad op", {16'd0, ip}, 32'd2);
        check("R9 AX untouched", {16'd0, g(0)}, 32'h0);
    endtask

    task automatic t_waits();
        prog = '{8'hB8, 8'h34, 8'h12, 8'hE7, 8'h55, 8'hFF};
        start(3, 2); run();
        check("R2 waits AX", {16'd0, g(0)}, 32'h1234);
        check("R2 waits addr0", {12'd0, faddr[0]}, 32'hFFFF0);
        check("R2 waits addr2", {12'd0, faddr[2]}, 32'hFFFF2);
        check("R12 waits port", {16'd0, wport[0]}, 32'h0055);
        check("R12 waits data", {16'd0, wdat[0]}, 32'h1234);
        check("R10 count waits", instr_count, 32'd2);
    endtask

    task automatic t_timing();
        prog = '{8'h90, 8'h90, 8'h90, 8'h90, 8'hFF};
        start(0, 0); run();
        check("R11 pitch first", fcyc[1] - fcyc[0], 32'd2);
        check("R11 pitch last", fcyc[4] - fcyc[3], 32'd2);
        check("R11 count nops", instr_count, 32'd4);
    endtask

    initial begin
        #1000000;
        nchecks++; nfails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end

    initial begin
        t_reset();
        t_movb();
        t_movw();
        t_jmpf();
        t_flags();
        t_in();
        t_out();
        t_halt();
        t_waits();
        t_timing();
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end
endmodule